// File: doc/BRIEF.md
# General-Purpose Register File with Write-Back Selection

This block holds the sixteen 16-bit general-purpose registers of a small processor datapath. It also selects where each write comes from and which instruction field addresses the second read port. One write port takes its data from the ALU result, the memory load data or the return address (PC+4) of a call. Two combinational read ports feed the ALU and the store path.

The first read port is addressed by the r1 field. The second read port is addressed by the r2 field, or by the r0 field when a control line asks for it. Branches and stores can then read two registers while the r2 bits carry an immediate. The write address is always the r0 field.

Writes are committed on the falling clock edge, halfway through the instruction. The rising edge that moves to the next instruction can then never race with the write enable. Register zero ignores writes and always reads as zero.

Top module: `gpr_writeback_file`

## Requirements
- R1: A write is committed on the falling clock edge and is readable on either port for the rest of that cycle. Changes to the write inputs after that falling edge do not alter the stored value.
- R2: Register zero always reads as zero, even after an enabled write addressed to it.
- R3: With `link_sel` = 1, the written value is `pc_plus4`.
- R4: With `mem_sel` = 1 and `link_sel` = 0, the written value is `load_data`.
- R5: With both `link_sel` and `mem_sel` at 1, `pc_plus4` is written, because link has priority.
- R6: With `link_sel` = 0 and `mem_sel` = 0, the written value is `alu_result`.
- R7: `rd_a_data` shows the register addressed by `fld_r1`, combinationally.
- R8: `rd_b_data` shows the register addressed by `fld_r2` when `rdb_use_r0` = 0, and by `fld_r0` when `rdb_use_r0` = 1.
- R9: With `wr_en` = 0, no register changes, whatever the other write inputs are.
- R10: `rst` is sampled on the falling edge, and while it is high it clears every register to zero. It takes priority over any write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the instruction changes on the rising edge, writes happen on the falling edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| wr_en | input | 1 | Write enable for the register addressed by `fld_r0` |
| fld_r0 | input | 4 | r0 field: write address, optional second read address |
| fld_r1 | input | 4 | r1 field: first read address |
| fld_r2 | input | 4 | r2 field: default second read address |
| rdb_use_r0 | input | 1 | 1 selects `fld_r0` as the second read address |
| link_sel | input | 1 | 1 writes `pc_plus4` (highest priority) |
| mem_sel | input | 1 | 1 writes `load_data` unless `link_sel` is set |
| alu_result | input | 16 | ALU output, the default write source |
| load_data | input | 16 | Data returned by a memory load |
| pc_plus4 | input | 16 | Return address written by a call |
| rd_a_data | output | 16 | Data of the register addressed by `fld_r1` |
| rd_b_data | output | 16 | Data of the register addressed by the selected second address |

## Verification
Several internal faults show up at the read ports within one clock cycle:
- A wrong source choice or a misplaced write shows at the read ports in the same cycle, just after the falling edge.
- A write taken on the wrong edge shows in the same cycle, because the readback taken before the next rising edge has not yet changed.
- A write that also captures late input changes shows in the same cycle as a different stored value.

Other corruption appears only when the register is next read:
- An unintended write.
- A write to register zero that was not blocked.

The bench therefore reads back every register after writing it, and reads untouched registers after disabled writes.

// File: rtl/gpr_pkg.sv
`timescale 1ns/1ps
package gpr_pkg;
  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_MEM  = 2'd1,
    WB_LINK = 2'd2
  } wb_src_e;
endpackage

// File: rtl/gpr_wb_mux.sv
`timescale 1ns/1ps
module gpr_wb_mux #(
  parameter int DW = 16
) (
  input  logic                   link_sel,
  input  logic                   mem_sel,
  input  logic [DW-1:0]          alu_result,
  input  logic [DW-1:0]          load_data,
  input  logic [DW-1:0]          pc_plus4,
  output gpr_pkg::wb_src_e       wb_src,
  output logic [DW-1:0]          wb_data
);
  import gpr_pkg::*;

  always_comb begin
    if (link_sel)     wb_src = WB_LINK;
    else if (mem_sel) wb_src = WB_MEM;
    else              wb_src = WB_ALU;
  end

  always_comb begin
    unique case (wb_src)
      WB_LINK: wb_data = pc_plus4;
      WB_MEM:  wb_data = load_data;
      default: wb_data = alu_result;
    endcase
  end
endmodule

// File: rtl/gpr_rd_sel.sv
`timescale 1ns/1ps
module gpr_rd_sel #(
  parameter int AW = 4
) (
  input  logic [AW-1:0] fld_r0,
  input  logic [AW-1:0] fld_r2,
  input  logic          use_r0,
  output logic [AW-1:0] rb_addr
);
  always_comb rb_addr = use_r0 ? fld_r0 : fld_r2;
endmodule

// File: rtl/gpr_storage.sv
`timescale 1ns/1ps
module gpr_storage #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] ra_addr,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] ra_data,
  output logic [DW-1:0] rb_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] regs [DEPTH];
  logic          wr_live;

  // Register zero is never a write target.
  assign wr_live = wr_en && (wr_addr != '0);

  // Falling-edge commit, mid-instruction.
  always_ff @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    ra_data = (ra_addr == '0) ? '0 : regs[ra_addr];
    rb_data = (rb_addr == '0) ? '0 : regs[rb_addr];
  end

  // R1
  commit_chk: assert property (@(negedge clk) disable iff (rst)
    wr_live |=> regs[$past(wr_addr)] == $past(wr_data));

  // R2
  zero_read_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_addr == '0) |-> (ra_data == '0));

  genvar g;
  generate
    for (g = 1; g < DEPTH; g++) begin : g_hold
      // R9
      hold_chk: assert property (@(negedge clk) disable iff (rst)
        !(wr_en && wr_addr == AW'(g)) |=> regs[g] == $past(regs[g]));
    end
  endgenerate
endmodule

// File: rtl/gpr_writeback_file.sv
`timescale 1ns/1ps
module gpr_writeback_file #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] fld_r0,
  input  logic [AW-1:0] fld_r1,
  input  logic [AW-1:0] fld_r2,
  input  logic          rdb_use_r0,
  input  logic          link_sel,
  input  logic          mem_sel,
  input  logic [DW-1:0] alu_result,
  input  logic [DW-1:0] load_data,
  input  logic [DW-1:0] pc_plus4,
  output logic [DW-1:0] rd_a_data,
  output logic [DW-1:0] rd_b_data
);
  gpr_pkg::wb_src_e wb_src;
  logic [DW-1:0]    wb_data;
  logic [AW-1:0]    rb_addr;

  gpr_wb_mux #(.DW(DW)) u_wb (
    .link_sel  (link_sel),
    .mem_sel   (mem_sel),
    .alu_result(alu_result),
    .load_data (load_data),
    .pc_plus4  (pc_plus4),
    .wb_src    (wb_src),
    .wb_data   (wb_data)
  );

  gpr_rd_sel #(.AW(AW)) u_rsel (
    .fld_r0 (fld_r0),
    .fld_r2 (fld_r2),
    .use_r0 (rdb_use_r0),
    .rb_addr(rb_addr)
  );

  gpr_storage #(.DW(DW), .AW(AW)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .wr_addr(fld_r0),
    .wr_data(wb_data),
    .ra_addr(fld_r1),
    .rb_addr(rb_addr),
    .ra_data(rd_a_data),
    .rb_data(rd_b_data)
  );

  // R3 R5
  link_wb_chk: assert property (@(negedge clk) disable iff (rst)
    link_sel |-> (wb_data == pc_plus4));

  // R4
  mem_wb_chk: assert property (@(negedge clk) disable iff (rst)
    (mem_sel && !link_sel) |-> (wb_data == load_data));

  // R6
  alu_wb_chk: assert property (@(negedge clk) disable iff (rst)
    (!mem_sel && !link_sel) |-> (wb_data == alu_result));

  // R8
  rdb_sel_chk: assert property (@(posedge clk) disable iff (rst)
    rdb_use_r0 |-> (rb_addr == fld_r0));
endmodule

// File: tb/gpr_writeback_file_test.sv
`timescale 1ns/1ps
module gpr_writeback_file_test;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  typedef struct {
    logic [DW-1:0] a_exp;
    logic [DW-1:0] b_exp;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] fld_r0 = '0, fld_r1 = '0, fld_r2 = '0;
  logic          rdb_use_r0 = 1'b0, link_sel = 1'b0, mem_sel = 1'b0;
  logic [DW-1:0] alu_result = '0, load_data = '0, pc_plus4 = '0;
  logic [DW-1:0] rd_a_data, rd_b_data;

  int checks = 0;
  int errors = 0;
  exp_t          sb_q[$];
  logic [DW-1:0] model [DEPTH];

  always #2 clk = ~clk;

  gpr_writeback_file #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .fld_r0(fld_r0), .fld_r1(fld_r1), .fld_r2(fld_r2),
    .rdb_use_r0(rdb_use_r0), .link_sel(link_sel), .mem_sel(mem_sel),
    .alu_result(alu_result), .load_data(load_data), .pc_plus4(pc_plus4),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data)
  );

  // Driver: one instruction per cycle, expected readback pushed to scoreboard
  task automatic cyc(input logic r, input logic we,
                     input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                     input logic [AW-1:0] a2, input logic use0,
                     input logic lk, input logic mm,
                     input logic [DW-1:0] alu, input logic [DW-1:0] ld,
                     input logic [DW-1:0] pc4, input string tag,
                     input logic late = 1'b0);
    exp_t e;
    @(posedge clk);
    #0.5;
    rst = r; wr_en = we; fld_r0 = a0; fld_r1 = a1; fld_r2 = a2;
    rdb_use_r0 = use0; link_sel = lk; mem_sel = mm;
    alu_result = alu; load_data = ld; pc_plus4 = pc4;
    if (r) begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
    end else if (we && a0 != '0) begin
      model[a0] = lk ? pc4 : (mm ? ld : alu);
    end
    e.a_exp = model[a1];
    e.b_exp = model[use0 ? a0 : a2];
    e.tag = tag;
    sb_q.push_back(e);
    if (late) begin
      #2.5;  // after the falling edge, before the monitor samples
      alu_result = ~alu; load_data = ~ld; pc_plus4 = ~pc4;
    end
  endtask

  // Monitor: samples half a ns before the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3.5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (rd_a_data !== e.a_exp) begin
          errors++;
          $display("FAIL %s port A got %h exp %h", e.tag, rd_a_data, e.a_exp);
        end
        checks++;
        if (rd_b_data !== e.b_exp) begin
          errors++;
          $display("FAIL %s port B got %h exp %h", e.tag, rd_b_data, e.b_exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    // R10 reset, with a write attempted during it
    cyc(1, 1, 4'd5, 4'd5, 4'd6, 0, 0, 0, 16'hdead, 0, 0, "R10 reset");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 reset");
    for (int i = 0; i < DEPTH; i += 2)
      cyc(0, 0, 0, 4'(i), 4'(i + 1), 0, 0, 0, 16'h5555, 0, 0, "R10 reset state");
    // R6 R7: ALU source, port A
    cyc(0, 1, 4'd1, 4'd1, 4'd0, 0, 0, 0, 16'h1111, 16'h9999, 16'h7777, "R6 alu write");
    // R4: load data source
    cyc(0, 1, 4'd2, 4'd2, 4'd1, 0, 0, 1, 16'h0bad, 16'h2222, 16'h7777, "R4 mem write");
    // R3: link source
    cyc(0, 1, 4'd3, 4'd3, 4'd2, 0, 1, 0, 16'h0bad, 16'h0bad, 16'h0104, "R3 link write");
    // R5: link beats mem
    cyc(0, 1, 4'd4, 4'd4, 4'd3, 0, 1, 1, 16'h0a0a, 16'h0b0b, 16'h0c0c, "R5 precedence");
    // R2: write to register zero ignored
    cyc(0, 1, 4'd0, 4'd0, 4'd0, 1, 0, 0, 16'hffff, 0, 0, "R2 zero reg");
    // R9: disabled write leaves register 1 alone
    cyc(0, 0, 4'd1, 4'd1, 4'd1, 1, 0, 0, 16'h4444, 16'h4444, 16'h4444, "R9 no write");
    // R8: second port from r2 then from r0
    cyc(0, 0, 4'd3, 4'd1, 4'd2, 0, 0, 0, 0, 0, 0, "R8 r2 select");
    cyc(0, 0, 4'd3, 4'd1, 4'd2, 1, 0, 0, 0, 0, 0, "R8 r0 select");
    // R1: inputs change after the falling edge; stored value must not follow
    cyc(0, 1, 4'd7, 4'd7, 4'd0, 1, 0, 0, 16'h3c3c, 16'h1234, 16'h5678, "R1 late change", 1'b1);
    cyc(0, 0, 4'd0, 4'd7, 4'd7, 0, 0, 0, 0, 0, 0, "R1 hold after edge");
    // R7 R8: fill all registers, then read them back
    for (int i = 1; i < DEPTH; i++)
      cyc(0, 1, 4'(i), 4'(i), 4'(i - 1), 0, 0, 0, 16'(16'h1000 * i + i), 0, 0, "R7 fill");
    for (int i = 0; i < DEPTH; i++)
      cyc(0, 0, 4'(DEPTH - 1 - i), 4'(i), 4'(i), 1, 0, 0, 0, 0, 0, "R7 R8 readback");
    // R10: mid-run reset clears everything
    cyc(1, 1, 4'd9, 4'd9, 4'd10, 0, 0, 0, 16'h7e7e, 0, 0, "R10 mid reset");
    for (int i = 0; i < DEPTH; i += 2)
      cyc(0, 0, 0, 4'(i), 4'(i + 1), 0, 0, 0, 0, 0, 0, "R10 cleared");
    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule